// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits between a processor's address path and two downstream buses. Each bus owns five windows, one for I/O and four for memory, and a separate 64 KiB window covers the chip's own register space. Software programs every window through a small word-addressed register port: a base field that places the window, a size field that sets its length in 64 KiB pages, and a remap value that sets where the window lands on the bus.

A combinational lookup port takes a processor address and reports three things: which window claims it, whether nothing claims it, and the bus address after translation. One enable register switches every window on or off. A clear bit turns its window on. A configuration bit chooses whether writing a base field also loads the low half of that window's remap value. This lets software that never touches remap registers get an identity-style mapping.

Top module: `addr_window_decoder`

## Requirements
- R1: The enable register (word 0x01, 21 bits) is active-low. A window takes part in decoding only while its bit is 0. Window w (0..9) uses bit 9+w, and the internal register space uses bit 20. Bits 0 to 8 and bit 19 have no effect on decoding.
- R2: A window starts at its 20-bit base field shifted left by 16. It covers (size+1) x 64 KiB. An address hits it when start <= address < start + length.
- R3: On a hit, lk_bus_addr is the window's 64-bit remap value plus the address's offset from the window start. For the internal register space, which is 64 KiB long, the remap value is zero.
- R4: Base writes keep only the bits in 0x030FFFFF for I/O windows (w = 0 and w = 5) and in 0x070FFFFF for memory windows. Size writes keep 16 bits. Internal base writes keep 0x000FFFFF.
- R5: A remap-low write puts wdata[15:0] into remap bits 31:16 and leaves bits 63:32 untouched. A remap-high write replaces bits 63:32 on memory windows only. On I/O windows that write is ignored, and the high half reads as 0.
- R6: A base write also puts wdata[15:0] into remap bits 31:16 of the same window when configuration bit 27 is 0. When bit 27 is 1, the remap value is unchanged.
- R7: A remap-low read returns remap bits 31:16 in rdata[15:0] with the upper bits zero. A remap-high read returns remap bits 63:32.
- R8: A configuration write (word 0x00) keeps only the bits in 0x0E4E3BFF and always sets bit 23.
- R9: After reset the configuration reads 0x028000FF, the enable register reads 0x0FBFFF, and the internal base reads 0x0100F100. Every window register reads 0.
- R10: When enabled windows overlap, the lowest window id wins. The window id is the enable-bit number, so window w is id 9+w and the internal space is id 20. A miss sets lk_miss, clears lk_hit, and drives lk_win and lk_bus_addr to 0.
- R11: The register map is as follows. The internal base is at word 0x02. Window w has its base at word 0x10+4w, size at +1, remap-low at +2 and remap-high at +3. Reads of any other word return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_addr | input | 36 | Processor address to decode |
| lk_hit | output | 1 | Some enabled window claims lk_addr |
| lk_miss | output | 1 | No enabled window claims lk_addr |
| lk_win | output | 5 | Id of the winning window (its enable bit number) |
| lk_bus_addr | output | 64 | Translated bus address |

## Verification
The bench sweeps all ten windows one at a time. For each window it probes the first and last byte inside the window and the bytes just outside it. This catches an off-by-one in the length, which would wrongly claim or drop the boundary bytes, and a reversed or misplaced enable bit, which would light the wrong id. It sets a remap value whose lower half overflows into bit 32, which catches a 32-bit adder. It stacks three enabled windows on one address to show priority by id. Finally it toggles configuration bit 27 around base writes, so a design that always or never copies into the remap value is exposed.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int NUM_BUS      = 2;
  localparam int MEM_PER_BUS  = 4;
  localparam int WIN_PER_BUS  = 1 + MEM_PER_BUS;
  localparam int NWIN         = NUM_BUS * WIN_PER_BUS;
  localparam int NSRC         = NWIN + 1;
  localparam int PAGE_SH      = 16;
  localparam int FIELD_W      = 20;
  localparam int SIZE_W       = 16;
  localparam int CPU_AW       = FIELD_W + PAGE_SH;
  localparam int REMAP_W      = 64;
  localparam int REG_W        = 32;
  localparam int EN_W         = 21;
  localparam int ID_W         = 5;
  localparam int FIRST_EN_BIT = 9;
  localparam int INT_EN_BIT   = 20;
  localparam int CFG_COPY_BIT = 27;
  localparam int RA_W         = 6;
  localparam int RA_CFG       = 0;
  localparam int RA_EN        = 1;
  localparam int RA_IBASE     = 2;
  localparam int RA_WIN0      = 16;

  localparam logic [REG_W-1:0] CFG_MASK      = 32'h0E4E_3BFF;
  localparam logic [REG_W-1:0] CFG_FORCE     = 32'h0080_0000;
  localparam logic [REG_W-1:0] IO_BASE_MASK  = 32'h030F_FFFF;
  localparam logic [REG_W-1:0] MEM_BASE_MASK = 32'h070F_FFFF;
  localparam logic [REG_W-1:0] IBASE_MASK    = 32'h000F_FFFF;
  localparam logic [REG_W-1:0] CFG_RST       = 32'h0280_00FF;
  localparam logic [REG_W-1:0] IBASE_RST     = 32'h0100_F100;
  localparam logic [EN_W-1:0]  EN_RST        = 21'h0F_BFFF;

  typedef struct packed {
    logic [REG_W-1:0]   base;
    logic [SIZE_W-1:0]  size;
    logic [REMAP_W-1:0] remap;
  } win_cfg_t;

  function automatic logic is_io(input int w);
    return (w % WIN_PER_BUS) == 0;
  endfunction

  function automatic logic [ID_W-1:0] src_id(input int i);
    return (i < NWIN) ? ID_W'(FIRST_EN_BIT + i) : ID_W'(INT_EN_BIT);
  endfunction

  function automatic logic [CPU_AW:0] win_start(input logic [FIELD_W-1:0] f);
    return {1'b0, f, {PAGE_SH{1'b0}}};
  endfunction

  function automatic logic [CPU_AW:0] win_len(input logic [SIZE_W-1:0] s);
    logic [CPU_AW:0] pages;
    pages = {{(CPU_AW+1-SIZE_W){1'b0}}, s} + (CPU_AW+1)'(1);
    return pages << PAGE_SH;
  endfunction

  function automatic logic win_hit(input logic [CPU_AW-1:0] a,
                                   input logic [CPU_AW:0] start,
                                   input logic [CPU_AW:0] len);
    logic [CPU_AW:0] ax;
    ax = {1'b0, a};
    return (ax >= start) && ((ax - start) < len);
  endfunction

  function automatic logic [REMAP_W-1:0] win_xlat(input logic [CPU_AW-1:0] a,
                                                  input logic [CPU_AW:0] start,
                                                  input logic [REMAP_W-1:0] remap);
    logic [CPU_AW:0] off;
    off = {1'b0, a} - start;
    return remap + {{(REMAP_W-CPU_AW-1){1'b0}}, off};
  endfunction
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int N_WIN = NWIN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [RA_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  output logic [EN_W-1:0]        en_o,
  output logic [FIELD_W-1:0]     ibase_o,
  output win_cfg_t [N_WIN-1:0]   win_o
);
  localparam int SLOT_W = RA_W - 2;

  logic [REG_W-1:0]     cfg_q;
  logic [EN_W-1:0]      en_q;
  logic [REG_W-1:0]     ibase_q;
  win_cfg_t [N_WIN-1:0] win_q;
  logic [N_WIN-1:0]     win_sel;

  always_comb begin
    for (int w = 0; w < N_WIN; w++) begin
      win_sel[w] = reg_we && (reg_addr[RA_W-1:2] == SLOT_W'(RA_WIN0 / 4 + w));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      en_q    <= EN_RST;
      ibase_q <= IBASE_RST;
      win_q   <= '0;
    end else if (reg_we) begin
      if (reg_addr == RA_W'(RA_CFG))   cfg_q   <= (reg_wdata & CFG_MASK) | CFG_FORCE;
      if (reg_addr == RA_W'(RA_EN))    en_q    <= reg_wdata[EN_W-1:0];
      if (reg_addr == RA_W'(RA_IBASE)) ibase_q <= reg_wdata & IBASE_MASK;
      for (int w = 0; w < N_WIN; w++) begin
        if (win_sel[w]) begin
          case (reg_addr[1:0])
            2'd0: begin
              win_q[w].base <= reg_wdata & (is_io(w) ? IO_BASE_MASK : MEM_BASE_MASK);
              if (!cfg_q[CFG_COPY_BIT]) win_q[w].remap[PAGE_SH +: 16] <= reg_wdata[15:0];
            end
            2'd1: win_q[w].size <= reg_wdata[SIZE_W-1:0];
            2'd2: win_q[w].remap[PAGE_SH +: 16] <= reg_wdata[15:0];
            default: if (!is_io(w)) win_q[w].remap[REMAP_W-1:32] <= reg_wdata;
          endcase
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_W'(RA_CFG))   reg_rdata = cfg_q;
    if (reg_addr == RA_W'(RA_EN))    reg_rdata = {{(REG_W-EN_W){1'b0}}, en_q};
    if (reg_addr == RA_W'(RA_IBASE)) reg_rdata = ibase_q;
    for (int w = 0; w < N_WIN; w++) begin
      if (reg_addr[RA_W-1:2] == SLOT_W'(RA_WIN0 / 4 + w)) begin
        case (reg_addr[1:0])
          2'd0:    reg_rdata = win_q[w].base;
          2'd1:    reg_rdata = {{(REG_W-SIZE_W){1'b0}}, win_q[w].size};
          2'd2:    reg_rdata = {16'h0, win_q[w].remap[PAGE_SH +: 16]};
          default: reg_rdata = win_q[w].remap[REMAP_W-1:32];
        endcase
      end
    end
  end

  assign en_o    = en_q;
  assign ibase_o = ibase_q[FIELD_W-1:0];
  assign win_o   = win_q;

  assert_cfg_b23_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[23]);

  for (genvar g = 0; g < N_WIN; g++) begin : g_chk
    assert_lo_keeps_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_sel[g] && reg_addr[1:0] == 2'd2)
        |=> win_q[g].remap[REMAP_W-1:32] == $past(win_q[g].remap[REMAP_W-1:32]));
    assert_base_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_sel[g] && reg_addr[1:0] == 2'd0 && !cfg_q[CFG_COPY_BIT])
        |=> win_q[g].remap[PAGE_SH +: 16] == $past(reg_wdata[15:0]));
  end
endmodule

// File: rtl/awd_window_match.sv
module awd_window_match
  import awd_pkg::*;
(
  input  logic [CPU_AW-1:0]  lk_addr,
  input  logic               active,
  input  logic [FIELD_W-1:0] base_field,
  input  logic [SIZE_W-1:0]  size_field,
  input  logic [REMAP_W-1:0] remap,
  output logic               hit,
  output logic [REMAP_W-1:0] xlat
);
  logic [CPU_AW:0] start;
  logic [CPU_AW:0] len;

  always_comb begin
    start = win_start(base_field);
    len   = win_len(size_field);
    hit   = active && win_hit(lk_addr, start, len);
    xlat  = win_xlat(lk_addr, start, remap);
  end
endmodule

// File: rtl/awd_pick.sv
module awd_pick
  import awd_pkg::*;
#(
  parameter int N_SRC = NSRC
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SRC-1:0]               hits,
  input  logic [N_SRC-1:0][REMAP_W-1:0]  xlats,
  output logic [N_SRC-1:0]               grant,
  output logic                           any,
  output logic [ID_W-1:0]                sel_id,
  output logic [REMAP_W-1:0]             sel_xlat
);
  always_comb begin
    grant    = '0;
    sel_id   = '0;
    sel_xlat = '0;
    any      = |hits;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hits[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        sel_id   = src_id(i);
        sel_xlat = xlats[i];
      end
    end
  end

  assert_onehot_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  for (genvar i = 1; i < N_SRC; i++) begin : g_pri
    assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> (hits[i] && hits[i-1:0] == '0));
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [5:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [35:0]         lk_addr,
  output logic                lk_hit,
  output logic                lk_miss,
  output logic [4:0]          lk_win,
  output logic [63:0]         lk_bus_addr
);
  logic [EN_W-1:0]               en;
  logic [FIELD_W-1:0]            ibase;
  win_cfg_t [NWIN-1:0]           win;
  logic [NSRC-1:0]               hits;
  logic [NSRC-1:0][REMAP_W-1:0]  xlats;
  logic [NSRC-1:0]               grant;
  logic                          any;
  logic [ID_W-1:0]               sel_id;
  logic [REMAP_W-1:0]            sel_xlat;

  awd_regfile #(.N_WIN(NWIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .en_o(en), .ibase_o(ibase), .win_o(win)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    awd_window_match u_match (
      .lk_addr(lk_addr), .active(!en[FIRST_EN_BIT + w]),
      .base_field(win[w].base[FIELD_W-1:0]), .size_field(win[w].size),
      .remap(win[w].remap), .hit(hits[w]), .xlat(xlats[w])
    );
  end

  awd_window_match u_int_match (
    .lk_addr(lk_addr), .active(!en[INT_EN_BIT]),
    .base_field(ibase), .size_field('0), .remap('0),
    .hit(hits[NWIN]), .xlat(xlats[NWIN])
  );

  awd_pick #(.N_SRC(NSRC)) u_pick (
    .clk(clk), .rst_n(rst_n), .hits(hits), .xlats(xlats),
    .grant(grant), .any(any), .sel_id(sel_id), .sel_xlat(sel_xlat)
  );

  assign lk_hit      = any;
  assign lk_miss     = !any;
  assign lk_win      = sel_id;
  assign lk_bus_addr = sel_xlat;

  logic [31:0] en_pad;
  assign en_pad = {{(32-EN_W){1'b0}}, en};

  assert_disabled_never_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !en_pad[lk_win]);

  assert_miss_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_win == '0 && lk_bus_addr == '0));
endmodule

// File: tb/addr_window_decoder_tb.sv
`timescale 1ns/1ps
module addr_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [35:0] lk_addr = '0;
  logic        lk_hit, lk_miss;
  logic [4:0]  lk_win;
  logic [63:0] lk_bus_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  addr_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_win(lk_win), .lk_bus_addr(lk_bus_addr)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic look(input logic [35:0] a);
    @(negedge clk);
    lk_addr = a;
    #1;
  endtask

  task automatic expect_hit(input string req, input logic [35:0] a,
                            input logic [4:0] id, input logic [63:0] xa);
    look(a);
    check(req, {63'h0, lk_hit}, 64'h1);
    check(req, {59'h0, lk_win}, {59'h0, id});
    check(req, lk_bus_addr, xa);
  endtask

  task automatic expect_miss(input string req, input logic [35:0] a);
    look(a);
    check(req, {63'h0, lk_miss}, 64'h1);
    check(req, {59'h0, lk_win}, 64'h0);
    check(req, lk_bus_addr, 64'h0);
  endtask

  function automatic logic [5:0] wreg(input int w, input int slot);
    return 6'(16 + 4 * w + slot);
  endfunction

  function automatic bit io_win(input int w);
    return (w == 0) || (w == 5);
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset values
    rd(6'h00, d); check("R9 cfg reset", {32'h0, d}, 64'h0280_00FF);
    rd(6'h01, d); check("R9 enable reset", {32'h0, d}, 64'h0F_BFFF);
    rd(6'h02, d); check("R9 ibase reset", {32'h0, d}, 64'h0100_F100);
    rd(wreg(3, 0), d); check("R9 window base reset", {32'h0, d}, 64'h0);
    // R3 internal space at 0xF100 << 16 and bus-1 I/O window (id 14) at 0
    expect_hit("R3 internal reset", 36'h0_F100_0010, 5'd20, 64'h10);
    expect_hit("R2 bus1 io reset", 36'h0_0000_1234, 5'd14, 64'h1234);
    expect_miss("R2 past end", 36'h0_0001_0000);

    // R8 configuration masking
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, d);
    check("R8 cfg mask", {32'h0, d}, 64'h0ECE_3BFF);
    wr(6'h00, 32'h0); rd(6'h00, d);
    check("R8 bit23 forced", {32'h0, d}, 64'h0080_0000);

    // R4 masks, R6 copy with bit 27 clear
    wr(wreg(0, 0), 32'hFFFF_FFFF); rd(wreg(0, 0), d);
    check("R4 io base mask", {32'h0, d}, 64'h030F_FFFF);
    wr(wreg(1, 0), 32'hFFFF_FFFF); rd(wreg(1, 0), d);
    check("R4 mem base mask", {32'h0, d}, 64'h070F_FFFF);
    rd(wreg(1, 2), d); check("R6 copy when clear", {32'h0, d}, 64'hFFFF);
    wr(wreg(1, 1), 32'hFFFF_FFFF); rd(wreg(1, 1), d);
    check("R4 size mask", {32'h0, d}, 64'hFFFF);
    wr(6'h02, 32'hFFFF_FFFF); rd(6'h02, d);
    check("R4 ibase mask", {32'h0, d}, 64'h000F_FFFF);

    // R6 no copy with bit 27 set
    wr(6'h00, 32'h0800_0000); rd(6'h00, d);
    check("R8 bit27 kept", {32'h0, d}, 64'h0880_0000);
    wr(wreg(2, 2), 32'h0000_ABCD);
    wr(wreg(2, 0), 32'h0000_1234);
    rd(wreg(2, 2), d); check("R6 no copy when set", {32'h0, d}, 64'hABCD);

    // R5 / R7 remap halves
    wr(wreg(1, 3), 32'h1234_5678);
    wr(wreg(1, 2), 32'hFFFF_9ABC);
    rd(wreg(1, 3), d); check("R5 low keeps high", {32'h0, d}, 64'h1234_5678);
    rd(wreg(1, 2), d); check("R7 low read", {32'h0, d}, 64'h9ABC);
    wr(wreg(0, 3), 32'hDEAD_BEEF); rd(wreg(0, 3), d);
    check("R5 io high ignored", {32'h0, d}, 64'h0);

    // R11 unmapped word
    wr(6'h05, 32'hFFFF_FFFF); rd(6'h05, d);
    check("R11 unmapped read", {32'h0, d}, 64'h0);
    rd(6'h01, d); check("R11 unmapped write no effect", {32'h0, d}, 64'h0F_BFFF);

    // R2/R3 sweep over every window, one enabled at a time
    wr(6'h01, 32'h001F_FFFF);
    for (int w = 0; w < 10; w++) begin
      wr(wreg(w, 0), 32'(32'h100 + 32'h40 * w));
      wr(wreg(w, 1), 32'(w));
      wr(wreg(w, 2), 32'(32'h1000 + w));
      if (!io_win(w)) wr(wreg(w, 3), 32'(w + 1));
    end
    for (int w = 0; w < 10; w++) begin
      logic [35:0] st;
      logic [35:0] ln;
      logic [63:0] rm;
      st = 36'(64'(32'h100 + 32'h40 * w) << 16);
      ln = 36'(64'(w + 1) << 16);
      rm = (io_win(w) ? 64'h0 : (64'(w + 1) << 32)) | (64'(32'h1000 + w) << 16);
      wr(6'h01, 32'h001F_FFFF & ~(32'h1 << (9 + w)));
      expect_hit("R2 window start", st, 5'(9 + w), rm);
      expect_hit("R3 window last", st + ln - 36'h1, 5'(9 + w), rm + 64'(ln) - 64'h1);
      expect_miss("R2 before start", st - 36'h1);
      expect_miss("R2 after end", st + ln);
    end

    // R1 bits 0-8 and 19 decode nothing
    wr(6'h01, 32'h0017_FE00);
    expect_miss("R1 unused enable bits", 36'h0_0100_0000);

    // R3 carry into bit 32
    wr(wreg(1, 2), 32'h0000_FFFF);
    wr(wreg(1, 3), 32'h0);
    wr(6'h01, 32'h001F_FBFF);
    expect_hit("R3 carry", 36'h0_0141_0004, 5'd10, 64'h1_0000_0004);

    // R10 overlap priority
    wr(wreg(1, 2), 32'h0000_1001);
    wr(wreg(1, 3), 32'h2);
    wr(wreg(7, 0), 32'h100);
    wr(6'h01, 32'h0018_01FF);
    expect_hit("R10 lowest id wins", 36'h0_0100_0000, 5'd9, 64'h1000_0000);
    wr(6'h01, 32'h0018_03FF);
    expect_hit("R10 next window", 36'h0_0100_0000, 5'd16, 64'h8_1007_0000);
    wr(6'h02, 32'h100);
    wr(6'h01, 32'h0008_03FF);
    expect_hit("R10 window beats internal", 36'h0_0100_0000, 5'd16, 64'h8_1007_0000);
    wr(6'h01, 32'h0009_03FF);
    expect_hit("R10 internal alone", 36'h0_0100_0020, 5'd20, 64'h20);
    wr(6'h01, 32'h001F_FFFF);
    expect_miss("R1 all disabled", 36'h0_0100_0020);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule